// File: doc/BRIEF.md
# Associative Cache Segment with Word-Pair Reuse

This block is one segment of a highly associative cache. A tag array searched in parallel (a content-addressable memory of one tag per way) decides whether a line is present, and the data store is organised as pairs of adjacent 32-bit words, so each read delivers two words. The pair last read is kept in a latch together with the way it came from. A processor that marks an access as sequential to the previous one can then be answered from the latch without a tag search or a data-store read. If a sequential access moves on to another pair of the same line, only the data store is read, using the remembered way.

The segment answers only addresses whose segment-select bits equal its own identity. A read that misses starts a linefill. Eight words are requested from the next level, and they are written into a victim way that a round-robin pointer chooses. The new tag is installed once the last beat has arrived. Writes always search the tags and update the word on a hit; a write miss allocates nothing. Two running counters report how many tag searches and how many processor-side data-store accesses took place, so that the accesses that were skipped can be seen.

The controller has two states. In `ST_LOOKUP` the segment accepts requests. The transition `lookup_to_fill` is taken on a read miss. In `ST_FILL` the segment collects beats, and the transition `fill_to_lookup` is taken on the eighth beat.

Top module: `cam_cache_segment`

## Requirements
- R1: After reset, `req_ready` is 1, `fill_req` and `rsp_valid` are 0, both counters are 0, and every way is invalid, so the first read misses.
- R2: A request is taken only when address bits [6:5] equal the segment identity (default 0). Any other request produces no response and leaves both counters unchanged.
- R3: A non-sequential read searches the tags once against address bits [31:7]. On a hit it reads one word pair, selected by bits [4:3], and raises `rsp_valid` with `rsp_hit`=1 in the next cycle. `rsp_rdata` carries the word selected by bit [2] (0 = lower address).
- R4: On a read miss the data store is not enabled. `fill_req` rises in the next cycle with `fill_addr` = the request address with bits [4:0] cleared, and `req_ready` is 0 until the fill ends. Beat k carries word k of the line. The cycle after the eighth beat gives `rsp_valid` with `rsp_hit`=0 and the requested word.
- R5: Victim ways are taken in round-robin order 0,1,…,63 and then wrap to 0. A filled line hits afterwards, and the line it displaced misses.
- R6: A read flagged sequential whose word lies in the latched pair is answered the next cycle from the latch, with `rsp_hit`=1. Neither counter changes.
- R7: A read flagged sequential that falls in the latched line but in another pair reads that pair from the latched way. The access counter rises by one, the search counter is unchanged, and the latch then holds the new pair.
- R8: A read flagged sequential whose line differs from the latched line is handled as in R3/R4.
- R9: A write always searches the tags. On a hit it stores the word, counts one data-store access and, if the word lies in the latched pair, also updates the latch. On a miss nothing is stored and no fill starts. In both cases the next cycle gives `rsp_valid` with `rsp_hit` showing the outcome and `rsp_rdata` echoing the write data.
- R10: Cycles with `fill_valid`=0 during a fill are ignored. A read miss clears the latch, so a sequential read after a fill performs a full search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Byte address of the word |
| req_seq | input | 1 | Access follows the previous one sequentially |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Segment accepts requests (state `ST_LOOKUP`) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Access found its line |
| rsp_rdata | output | 32 | Read word, or echoed write data |
| fill_req | output | 1 | Linefill in progress |
| fill_addr | output | 32 | Line base address of the fill |
| fill_valid | input | 1 | Fill beat present |
| fill_data | input | 32 | Fill beat word |
| cam_search_count | output | 16 | Number of tag searches |
| ram_access_count | output | 16 | Number of processor-side data-store accesses |

## Verification
The assertions assume that a requester offers a request only while `req_ready` is high, and that `fill_valid` is raised only while `fill_req` is high. The bench drives a request only after the previous response or fill has completed, and drives fill beats only from inside the fill sequence. Both assumptions therefore hold by construction of the stimulus. The assertions also assume that a tag is never installed twice. The bench keeps this true by filling a line only after the model has predicted a miss for it.

// File: rtl/cseg_pkg.sv
`timescale 1ns/1ps
package cseg_pkg;
    typedef enum logic [0:0] {
        ST_LOOKUP,
        ST_FILL
    } seg_state_e;

    typedef enum logic [1:0] {
        PATH_NONE,
        PATH_LATCH,
        PATH_PAIR,
        PATH_SEARCH
    } access_path_e;
endpackage

// File: rtl/cseg_tag_cam.sv
`timescale 1ns/1ps
module cseg_tag_cam #(
    parameter int WAYS  = 64,
    parameter int TAG_W = 25,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] search_tag,
    output logic [WAYS-1:0]  match_vec,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] victim_way,
    input  logic             drop_en,
    input  logic             install_en,
    input  logic [TAG_W-1:0] install_tag
);
    logic [TAG_W-1:0] tag_q [WAYS];
    logic [WAYS-1:0]  vld_q;
    logic [WAY_W-1:0] rr_q;

    // Valid bits and victim pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            rr_q  <= '0;
        end else begin
            if (drop_en)
                vld_q[rr_q] <= 1'b0;
            if (install_en) begin
                vld_q[rr_q] <= 1'b1;
                rr_q <= (rr_q == WAY_W'(WAYS-1)) ? '0 : rr_q + WAY_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (install_en)
            tag_q[rr_q] <= install_tag;
    end

    // One comparator per way
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign match_vec[g] = vld_q[g] && (tag_q[g] == search_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int i = 0; i < WAYS; i++)
            if (match_vec[i])
                hit_way = WAY_W'(i);
    end

    assign hit        = |match_vec;
    assign victim_way = rr_q;
endmodule

// File: rtl/cseg_pair_ram.sv
`timescale 1ns/1ps
module cseg_pair_ram #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 256,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rd_en,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [2*WORD_W-1:0] rd_pair,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic                wr_sel,
    input  logic [WORD_W-1:0]   wr_data
);
    // Two word banks: bank 0 holds the lower-addressed word of each pair
    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [WORD_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == 1'(b)))
                mem[wr_idx] <= wr_data;
        end

        assign rd_pair[b*WORD_W +: WORD_W] = rd_en ? mem[rd_idx] : '0;
    end
endmodule

// File: rtl/cam_cache_segment.sv
`timescale 1ns/1ps
module cam_cache_segment #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int WAYS       = 64,
    parameter int LINE_WORDS = 8,
    parameter int SEG_BITS   = 2,
    parameter int SEG_ID     = 0,
    parameter int CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_seq,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    output logic [CNT_W-1:0]  cam_search_count,
    output logic [CNT_W-1:0]  ram_access_count
);
    import cseg_pkg::*;

    localparam int WSEL_W  = $clog2(LINE_WORDS);
    localparam int PSEL_W  = WSEL_W - 1;
    localparam int OFF_W   = WSEL_W + 2;
    localparam int TAG_LSB = OFF_W + SEG_BITS;
    localparam int TAG_W   = ADDR_W - TAG_LSB;
    localparam int LINE_W  = ADDR_W - OFF_W;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int RIDX_W  = WAY_W + PSEL_W;

    seg_state_e   state_q, state_d;
    access_path_e path;

    logic [TAG_W-1:0]    req_tag;
    logic [LINE_W-1:0]   req_line;
    logic [PSEL_W-1:0]   req_psel;
    logic                req_wsel;
    logic                seg_ok;

    logic [WAYS-1:0]     cam_match;
    logic                cam_hit;
    logic [WAY_W-1:0]    cam_way;
    logic [WAY_W-1:0]    victim_way;
    logic                cam_search;

    logic                ram_rd_en;
    logic [RIDX_W-1:0]   ram_rd_idx;
    logic [2*DATA_W-1:0] ram_rd_pair;
    logic [DATA_W-1:0]   ram_word;
    logic                ram_wr_en;
    logic [RIDX_W-1:0]   ram_wr_idx;
    logic                ram_wr_sel;
    logic [DATA_W-1:0]   ram_wr_data;

    logic                latch_vld_q;
    logic [LINE_W-1:0]   latch_line_q;
    logic [PSEL_W-1:0]   latch_psel_q;
    logic [WAY_W-1:0]    latch_way_q;
    logic [1:0][DATA_W-1:0] latch_data_q;
    logic                in_line, in_pair;

    logic [ADDR_W-1:0]   miss_addr_q;
    logic [WSEL_W-1:0]   beat_q;
    logic [DATA_W-1:0]   crit_q;
    logic                beat_en, last_beat, write_hit, read_hit, read_miss;
    logic                unused_bits;

    assign req_tag  = req_addr[ADDR_W-1:TAG_LSB];
    assign req_line = req_addr[ADDR_W-1:OFF_W];
    assign req_psel = req_addr[OFF_W-1:3];
    assign req_wsel = req_addr[2];
    assign seg_ok   = req_addr[TAG_LSB-1:OFF_W] == SEG_BITS'(SEG_ID);
    assign unused_bits = ^{req_addr[1:0], miss_addr_q[1:0]};

    assign in_line = latch_vld_q && (latch_line_q == req_line);
    assign in_pair = in_line && (latch_psel_q == req_psel);

    // Which resources the current request needs
    always_comb begin
        path = PATH_NONE;
        if (state_q == ST_LOOKUP && req_valid && seg_ok) begin
            if (req_write)              path = PATH_SEARCH;
            else if (req_seq && in_pair) path = PATH_LATCH;
            else if (req_seq && in_line) path = PATH_PAIR;
            else                         path = PATH_SEARCH;
        end
    end

    assign cam_search = (path == PATH_SEARCH);
    assign read_hit   = cam_search && !req_write && cam_hit;
    assign read_miss  = cam_search && !req_write && !cam_hit;
    assign write_hit  = cam_search && req_write && cam_hit;
    assign beat_en    = (state_q == ST_FILL) && fill_valid;
    assign last_beat  = beat_en && (beat_q == WSEL_W'(LINE_WORDS-1));

    assign ram_rd_en  = (path == PATH_PAIR) || read_hit;
    assign ram_rd_idx = (path == PATH_PAIR) ? {latch_way_q, req_psel} : {cam_way, req_psel};
    assign ram_word   = req_wsel ? ram_rd_pair[2*DATA_W-1:DATA_W] : ram_rd_pair[DATA_W-1:0];
    assign ram_wr_en  = write_hit || beat_en;
    assign ram_wr_idx = beat_en ? {victim_way, beat_q[WSEL_W-1:1]} : {cam_way, req_psel};
    assign ram_wr_sel = beat_en ? beat_q[0] : req_wsel;
    assign ram_wr_data = beat_en ? fill_data : req_wdata;

    cseg_tag_cam #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_cam (
        .clk         (clk),
        .rst_n       (rst_n),
        .search_tag  (req_tag),
        .match_vec   (cam_match),
        .hit         (cam_hit),
        .hit_way     (cam_way),
        .victim_way  (victim_way),
        .drop_en     (read_miss),
        .install_en  (last_beat),
        .install_tag (miss_addr_q[ADDR_W-1:TAG_LSB])
    );

    cseg_pair_ram #(.WORD_W(DATA_W), .DEPTH(WAYS*LINE_WORDS/2), .IDX_W(RIDX_W)) u_ram (
        .clk     (clk),
        .rd_en   (ram_rd_en),
        .rd_idx  (ram_rd_idx),
        .rd_pair (ram_rd_pair),
        .wr_en   (ram_wr_en),
        .wr_idx  (ram_wr_idx),
        .wr_sel  (ram_wr_sel),
        .wr_data (ram_wr_data)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP: if (read_miss) state_d = ST_FILL;    // lookup_to_fill
            ST_FILL:   if (last_beat) state_d = ST_LOOKUP;  // fill_to_lookup
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    // Latch, response and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_vld_q      <= 1'b0;
            latch_line_q     <= '0;
            latch_psel_q     <= '0;
            latch_way_q      <= '0;
            latch_data_q     <= '0;
            miss_addr_q      <= '0;
            beat_q           <= '0;
            crit_q           <= '0;
            rsp_valid        <= 1'b0;
            rsp_hit          <= 1'b0;
            rsp_rdata        <= '0;
            cam_search_count <= '0;
            ram_access_count <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (path)
                PATH_LATCH: begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b1;
                    rsp_rdata <= latch_data_q[req_wsel];
                end
                PATH_PAIR: begin
                    rsp_valid        <= 1'b1;
                    rsp_hit          <= 1'b1;
                    rsp_rdata        <= ram_word;
                    latch_psel_q     <= req_psel;
                    latch_data_q     <= ram_rd_pair;
                    ram_access_count <= ram_access_count + CNT_W'(1);
                end
                PATH_SEARCH: begin
                    cam_search_count <= cam_search_count + CNT_W'(1);
                    if (req_write) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= cam_hit;
                        rsp_rdata <= req_wdata;
                        if (cam_hit) begin
                            ram_access_count <= ram_access_count + CNT_W'(1);
                            if (in_pair)
                                latch_data_q[req_wsel] <= req_wdata;
                        end
                    end else if (cam_hit) begin
                        rsp_valid        <= 1'b1;
                        rsp_hit          <= 1'b1;
                        rsp_rdata        <= ram_word;
                        latch_vld_q      <= 1'b1;
                        latch_line_q     <= req_line;
                        latch_psel_q     <= req_psel;
                        latch_way_q      <= cam_way;
                        latch_data_q     <= ram_rd_pair;
                        ram_access_count <= ram_access_count + CNT_W'(1);
                    end else begin
                        latch_vld_q <= 1'b0;
                        miss_addr_q <= req_addr;
                        beat_q      <= '0;
                    end
                end
                PATH_NONE: begin
                    if (beat_en) begin
                        beat_q <= beat_q + WSEL_W'(1);
                        if (beat_q == miss_addr_q[OFF_W-1:2])
                            crit_q <= fill_data;
                        if (last_beat) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b0;
                            rsp_rdata <= (beat_q == miss_addr_q[OFF_W-1:2]) ? fill_data : crit_q;
                        end
                    end
                end
            endcase
        end
    end

    assign req_ready = (state_q == ST_LOOKUP);
    assign fill_req  = (state_q == ST_FILL);
    assign fill_addr = {miss_addr_q[ADDR_W-1:OFF_W], OFF_W'(0)};
endmodule

// File: rtl/cseg_checker.sv
`timescale 1ns/1ps
module cseg_checker #(
    parameter int WAYS     = 64,
    parameter int SEG_BITS = 2,
    parameter int SEG_ID   = 0,
    parameter int CNT_W    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [SEG_BITS-1:0] req_seg,
    input logic                fill_req,
    input logic                rsp_valid,
    input logic                cam_search,
    input logic                cam_hit,
    input logic                ram_rd_en,
    input logic [WAYS-1:0]     match_vec,
    input logic [CNT_W-1:0]    search_cnt,
    input logic [CNT_W-1:0]    access_cnt
);
    // R4
    no_ram_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cam_search && !cam_hit) |-> !ram_rd_en);

    // R3
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R3
    search_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cam_search |=> (rsp_valid || fill_req));

    // R4
    busy_during_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (!req_ready && !rsp_valid));

    // R2
    foreign_segment_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_seg != SEG_BITS'(SEG_ID)) |=> !rsp_valid);

    // R6
    search_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (search_cnt == $past(search_cnt) || search_cnt == $past(search_cnt) + CNT_W'(1)));

    // R7
    access_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (access_cnt == $past(access_cnt) || access_cnt == $past(access_cnt) + CNT_W'(1)));
endmodule

bind cam_cache_segment cseg_checker #(
    .WAYS(WAYS), .SEG_BITS(SEG_BITS), .SEG_ID(SEG_ID), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_seg    (req_addr[OFF_W+SEG_BITS-1:OFF_W]),
    .fill_req   (fill_req),
    .rsp_valid  (rsp_valid),
    .cam_search (cam_search),
    .cam_hit    (cam_hit),
    .ram_rd_en  (ram_rd_en),
    .match_vec  (cam_match),
    .search_cnt (cam_search_count),
    .access_cnt (ram_access_count)
);

// File: tb/tb_cam_cache_segment.sv
`timescale 1ns/1ps
module tb_cam_cache_segment;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_seq = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_hit, fill_req;
    logic [31:0] rsp_rdata, fill_addr;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;
    logic [15:0] cam_search_count, ram_access_count;

    always #2.5 clk = ~clk;

    cam_cache_segment dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_seq(req_seq),
        .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_rdata(rsp_rdata), .fill_req(fill_req), .fill_addr(fill_addr),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .cam_search_count(cam_search_count), .ram_access_count(ram_access_count)
    );

    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    bit    run_chk = 0;
    string cur_req = "R1";

    // Behavioural model state
    logic [24:0] m_tag [64];
    bit          m_vld [64];
    logic [31:0] m_data [512];
    int          m_rr = 0;
    bit          l_vld = 0;
    logic [26:0] l_line = '0;
    logic [1:0]  l_psel = '0;
    int          l_way = 0;

    logic        e_ready = 1'b1, e_fill = 1'b0, e_rsp = 1'b0, e_hit = 1'b0;
    logic [31:0] e_data = '0, e_faddr = '0;
    logic [15:0] e_cs = '0, e_cr = '0;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    function automatic int find_way(input logic [24:0] t);
        for (int i = 0; i < 64; i++)
            if (m_vld[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    task automatic chk(input string field, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, field, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the rising edge
    always @(negedge clk) begin
        if (run_chk) begin
            chk("req_ready", 32'(req_ready), 32'(e_ready));
            chk("fill_req", 32'(fill_req), 32'(e_fill));
            chk("rsp_valid", 32'(rsp_valid), 32'(e_rsp));
            chk("search count", 32'(cam_search_count), 32'(e_cs));
            chk("access count", 32'(ram_access_count), 32'(e_cr));
            if (e_rsp) begin
                chk("rsp_hit", 32'(rsp_hit), 32'(e_hit));
                chk("rsp_rdata", rsp_rdata, e_data);
            end
            if (e_fill) chk("fill_addr", fill_addr, e_faddr);
            e_rsp = 1'b0;
        end
    end

    task automatic do_fill(input logic [31:0] a, input bit gap);
        logic [31:0] base;
        base = {a[31:5], 5'b0};
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (gap && k == 3) @(negedge clk);
            fill_valid = 1'b1;
            fill_data  = mem_word(base + 32'(4 * k));
            @(posedge clk);
            #1;
            fill_valid = 1'b0;
            m_data[m_rr * 8 + k] = mem_word(base + 32'(4 * k));
        end
        m_tag[m_rr] = a[31:7];
        m_vld[m_rr] = 1'b1;
        m_rr = (m_rr + 1) % 64;
        e_fill = 1'b0; e_ready = 1'b1;
        e_rsp = 1'b1; e_hit = 1'b0; e_data = mem_word({a[31:2], 2'b00});
    endtask

    task automatic access(input string rq, input logic [31:0] a, input bit sq,
                          input bit wr, input logic [31:0] wd, input bit gap);
        logic [26:0] ln;
        logic [1:0]  ps;
        int          wi, way;
        bit          miss;
        cur_req = rq;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_seq = sq; req_write = wr; req_wdata = wd;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        ln = a[31:5]; ps = a[4:3]; wi = int'(a[4:2]); miss = 0;
        if (a[6:5] == 2'b00) begin
            if (wr) begin
                e_cs++;
                way = find_way(a[31:7]);
                e_rsp = 1'b1; e_data = wd; e_hit = (way >= 0);
                if (way >= 0) begin
                    m_data[way * 8 + wi] = wd;
                    e_cr++;
                end
            end else if (sq && l_vld && l_line == ln && l_psel == ps) begin
                e_rsp = 1'b1; e_hit = 1'b1; e_data = m_data[l_way * 8 + wi];
            end else if (sq && l_vld && l_line == ln) begin
                e_cr++;
                l_psel = ps;
                e_rsp = 1'b1; e_hit = 1'b1; e_data = m_data[l_way * 8 + wi];
            end else begin
                e_cs++;
                way = find_way(a[31:7]);
                if (way >= 0) begin
                    e_cr++;
                    l_vld = 1; l_line = ln; l_psel = ps; l_way = way;
                    e_rsp = 1'b1; e_hit = 1'b1; e_data = m_data[way * 8 + wi];
                end else begin
                    miss = 1;
                    l_vld = 0;
                    m_vld[m_rr] = 1'b0;
                    e_fill = 1'b1; e_ready = 1'b0; e_faddr = {ln, 5'b0};
                end
            end
        end
        if (miss) do_fill(a, gap);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1 reset";
        chk("req_ready", 32'(req_ready), 32'd1);
        chk("fill_req", 32'(fill_req), 32'd0);
        chk("rsp_valid", 32'(rsp_valid), 32'd0);
        chk("search count", 32'(cam_search_count), 32'd0);
        chk("access count", 32'(ram_access_count), 32'd0);
        run_chk = 1;

        access("R1/R4/R10 first read misses, fill with a stall", 32'h0000_1014, 0, 0, 0, 1);
        access("R3 non-sequential hit", 32'h0000_1000, 0, 0, 0, 0);
        access("R6 sequential in latched pair", 32'h0000_1004, 1, 0, 0, 0);
        access("R7 sequential into next pair", 32'h0000_1008, 1, 0, 0, 0);
        access("R6 sequential upper word", 32'h0000_100C, 1, 0, 0, 0);
        access("R7 sequential pair crossing again", 32'h0000_1018, 1, 0, 0, 0);
        access("R8 sequential to other line misses", 32'h0000_2008, 1, 0, 0, 0);
        access("R10 sequential after fill searches", 32'h0000_200C, 1, 0, 0, 0);
        access("R2 foreign segment ignored", 32'h0000_1020, 0, 0, 0, 0);
        access("R2 foreign segment sequential ignored", 32'h0000_2064, 1, 0, 0, 0);
        access("R6 latch intact after foreign", 32'h0000_2008, 1, 0, 0, 0);
        access("R3 non-sequential hit pair 1", 32'h0000_1008, 0, 0, 0, 0);
        access("R9 write hit into latched pair", 32'h0000_100C, 0, 1, 32'hCAFE_0001, 0);
        access("R9 latch shows written word", 32'h0000_100C, 1, 0, 0, 0);
        access("R9 write hit other pair", 32'h0000_1010, 1, 1, 32'hBEEF_0002, 0);
        access("R9 pair read shows written word", 32'h0000_1010, 1, 0, 0, 0);
        access("R9 write miss allocates nothing", 32'h0000_3004, 0, 1, 32'h1234_5678, 0);
        access("R9 read after write miss still misses", 32'h0000_3004, 0, 0, 0, 0);
        access("R4 miss on last word of line", 32'h0000_401C, 0, 0, 0, 0);

        for (int k = 0; k < 62; k++)
            access("R5 round-robin fill", 32'h0001_0000 + 32'(k) * 32'h80 + 32'(k % 8) * 4, 0, 0, 0, 0);
        access("R5 evicted line misses", 32'h0000_1000, 0, 0, 0, 0);
        access("R5 surviving line hits", 32'h0001_0000 + 32'd20 * 32'h80, 0, 0, 0, 0);
        access("R5 wrapped victim hits", 32'h0001_0000 + 32'd61 * 32'h80 + 32'h14, 0, 0, 0, 0);
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #500us;
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog timeout act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule